// File: doc/BRIEF.md
# Dual-Mode 8-bit PWM Channel

This block produces one pulse-width-modulated output from an 8-bit counter. The counter either counts up and wraps (left-aligned mode) or runs a triangle, rising to the period value and falling back to zero (center-aligned mode). It advances only on cycles when an external prescaler raises a one-cycle tick strobe. A period value and a duty value are compared against the count. A polarity bit selects whether the duty value sets the active-high share or the active-low share of each period.

Software writes period and duty into shadow registers. While the channel runs, the shadow values move into the active registers only at a safe point in the count: at the wrap in left-aligned mode, and at the bottom of the triangle in center-aligned mode. While the channel is disabled, the shadow values pass straight through. The alignment bit is meant to be set only while the channel is disabled.

Top module: `pwm_dual_chan`

## Requirements
- R1: While `rst_n` is low, `pwm_out` is 0, and every internal register (shadow values, active values, count, direction) is cleared.
- R2: Left-aligned mode (`center_mode`=0), enabled, active period P≥1: each tick moves the count 0,1,…,P−1 and then back to 0, so one output period lasts P ticks.
- R3: Left-aligned output level, with count c and active duty D. When `polarity`=1 the output is high while c<D, so the high share is D/P. When `polarity`=0 the output is low while c<D, so the high share is (P−D)/P. Example: P=4, D=1, `polarity`=0 gives 3 high ticks out of every 4.
- R4: A duty of 0 keeps the output at the inactive level (the inverse of `polarity`) for the whole period. A duty ≥ P keeps it at the `polarity` level for the whole period.
- R5: Center-aligned mode (`center_mode`=1), P≥1: the count rises 0→P and then falls back to 0. The direction turns down when the count reaches P and turns up again at 0. One output period is 2·P ticks.
- R6: In center-aligned mode the output changes at the duty value both on the way up and on the way down. It is at the `polarity` level for 2·D ticks of each period (D≤P), on either side of count 0.
- R7: While the channel is enabled, a write to period (`wr_period`) or duty (`wr_duty`) stores `wr_data` in a shadow register only. The active value changes only when the count returns to 0: at the wrap in left-aligned mode, and at the end of the falling slope in center-aligned mode.
- R8: While `chan_en`=0, the count is held at 0 with the direction up. One clock later the output is the inverse of `polarity`. The active registers take the shadow values on every clock, so the first enabled cycle uses the latest writes.
- R9: An active period of 0 stops counting. One clock later the output is the `polarity` level, whatever the duty.
- R10: On a clock without `tick_en`, the count, the direction and the output hold their values.
- R11: `pwm_out` is registered. It shows the level that belongs to the count, direction and active values present during the previous clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | One-cycle strobe from the prescaler; advances the count |
| chan_en | input | 1 | Channel enable |
| center_mode | input | 1 | 1 = center-aligned, 0 = left-aligned |
| polarity | input | 1 | Level driven while the count is inside the duty window |
| wr_period | input | 1 | Write strobe for the period shadow register |
| wr_duty | input | 1 | Write strobe for the duty shadow register |
| wr_data | input | 8 | Value written by either strobe |
| pwm_out | output | 1 | PWM output pin |

## Verification
The count, the direction and the active registers change on the same rising edge that samples a tick, a reload or an enable change. `pwm_out` follows one edge later, because it is registered from that state. The bench keeps its own model state, updates it on the same rising edge from the same inputs, and registers its expected output with the same one-edge delay. It then compares `pwm_out` at the falling edge, half a cycle after every change. The duty-share checks count high samples over windows of one full output period, taken after a settling delay, so the measured share does not depend on the window phase.

// File: rtl/pwm_pkg.sv
// Package: shared types for the dual-mode PWM channel.
// Assumes: nothing beyond IEEE 1800-2017.
package pwm_pkg;
    // Counting direction of the channel counter.
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    // Width of the channel counter and its compare registers.
    localparam int unsigned PWM_W = 8;

    // Number of double-buffered registers (period, duty).
    localparam int unsigned NUM_BUF = 2;
    localparam int unsigned IDX_PER = 0;
    localparam int unsigned IDX_DUT = 1;
endpackage

// File: rtl/pwm_shadow_regs.sv
// Module: pwm_shadow_regs
// Double-buffered period and duty storage. Writes land in the shadow copy.
// The active copy takes the shadow copy whenever load_i is high.
// Assumes: load_i is high on every clock while the channel is disabled,
// and on safe reload points otherwise.
module pwm_shadow_regs #(
    parameter int unsigned W = pwm_pkg::PWM_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_per_i,
    input  logic         wr_dut_i,
    input  logic [W-1:0] wdata_i,
    input  logic         load_i,
    output logic [W-1:0] act_per_o,
    output logic [W-1:0] act_dut_o
);
    localparam int unsigned N = pwm_pkg::NUM_BUF;

    logic [N-1:0]        wr_vec;
    logic [N-1:0][W-1:0] shd_q;
    logic [N-1:0][W-1:0] act_q;

    assign wr_vec[pwm_pkg::IDX_PER] = wr_per_i;
    assign wr_vec[pwm_pkg::IDX_DUT] = wr_dut_i;

    for (genvar g = 0; g < N; g++) begin : g_buf
        // Shadow copy: capture software writes.
        always_ff @(posedge clk) begin
            if (!rst_n)         shd_q[g] <= '0;
            else if (wr_vec[g]) shd_q[g] <= wdata_i;
        end

        // Active copy: follow the shadow copy only at a reload point.
        always_ff @(posedge clk) begin
            if (!rst_n)      act_q[g] <= '0;
            else if (load_i) act_q[g] <= shd_q[g];
        end
    end

    assign act_per_o = act_q[pwm_pkg::IDX_PER];
    assign act_dut_o = act_q[pwm_pkg::IDX_DUT];
endmodule

// File: rtl/pwm_counter.sv
// Module: pwm_counter
// Channel counter. In left-aligned mode it counts up and wraps at per-1.
// In center-aligned mode it runs a triangle 0..per..0.
// reload_o flags the edges where the active registers may be refreshed.
// Assumes: center_i changes only while en_i is low.
module pwm_counter #(
    parameter int unsigned W = pwm_pkg::PWM_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          tick_i,
    input  logic          center_i,
    input  logic [W-1:0]  per_i,
    output logic [W-1:0]  cnt_o,
    output pwm_pkg::dir_e dir_o,
    output logic          reload_o
);
    import pwm_pkg::*;

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q, cnt_d;
    dir_e         dir_q, dir_d;
    logic         reload;

    // Next-state selection for count, direction and reload strobe.
    always_comb begin
        cnt_d  = cnt_q;
        dir_d  = dir_q;
        reload = 1'b0;
        if (!en_i) begin
            cnt_d  = '0;
            dir_d  = DIR_UP;
            reload = 1'b1;
        end else if (tick_i) begin
            if (per_i == '0) begin
                cnt_d  = '0;
                dir_d  = DIR_UP;
                reload = 1'b1;
            end else if (!center_i) begin
                dir_d = DIR_UP;
                if (cnt_q >= per_i - ONE) begin
                    cnt_d  = '0;
                    reload = 1'b1;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end else if (dir_q == DIR_UP) begin
                cnt_d = cnt_q + ONE;
                if (cnt_q + ONE >= per_i) dir_d = DIR_DOWN;
            end else begin
                if (cnt_q <= ONE) begin
                    cnt_d  = '0;
                    dir_d  = DIR_UP;
                    reload = 1'b1;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
        end
    end

    // State registers for count and direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dir_q <= DIR_UP;
        end else begin
            cnt_q <= cnt_d;
            dir_q <= dir_d;
        end
    end

    assign cnt_o    = cnt_q;
    assign dir_o    = dir_q;
    assign reload_o = reload;
endmodule

// File: rtl/pwm_out_stage.sv
// Module: pwm_out_stage
// Duty compare, polarity handling and the output flip-flop.
// Rising slope: the duty window is count < duty. Falling slope: count <= duty.
// This gives 2*duty window ticks per triangle.
// Assumes: inputs are the registered state of the counter and buffers.
module pwm_out_stage #(
    parameter int unsigned W = pwm_pkg::PWM_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          pol_i,
    input  logic [W-1:0]  cnt_i,
    input  pwm_pkg::dir_e dir_i,
    input  logic [W-1:0]  per_i,
    input  logic [W-1:0]  dut_i,
    output logic          pwm_o
);
    import pwm_pkg::*;

    logic in_window;
    logic level;
    logic out_q;

    // Duty compare, direction-dependent at the turning edge.
    always_comb begin
        if (dir_i == DIR_UP) in_window = (cnt_i < dut_i);
        else                 in_window = (cnt_i <= dut_i);
    end

    // Level selection: disabled, zero period, or duty compare with polarity.
    always_comb begin
        if (!en_i)              level = ~pol_i;
        else if (per_i == '0)   level = pol_i;
        else                    level = in_window ? pol_i : ~pol_i;
    end

    // Output flip-flop.
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= level;
    end

    assign pwm_o = out_q;
endmodule

// File: rtl/pwm_dual_chan.sv
// Module: pwm_dual_chan (top)
// One 8-bit PWM channel with left- or center-aligned counting,
// double-buffered period and duty, and selectable polarity.
// Assumes: tick_en is a one-clock strobe from an external prescaler;
// center_mode is changed only while chan_en is low.
module pwm_dual_chan #(
    parameter int unsigned W = pwm_pkg::PWM_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         chan_en,
    input  logic         center_mode,
    input  logic         polarity,
    input  logic         wr_period,
    input  logic         wr_duty,
    input  logic [W-1:0] wr_data,
    output logic         pwm_out
);
    logic [W-1:0]  cnt_w;
    pwm_pkg::dir_e dir_w;
    logic          reload_w;
    logic [W-1:0]  act_per_w;
    logic [W-1:0]  act_dut_w;

    pwm_shadow_regs #(.W(W)) u_bufs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_per_i  (wr_period),
        .wr_dut_i  (wr_duty),
        .wdata_i   (wr_data),
        .load_i    (reload_w),
        .act_per_o (act_per_w),
        .act_dut_o (act_dut_w)
    );

    pwm_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (chan_en),
        .tick_i   (tick_en),
        .center_i (center_mode),
        .per_i    (act_per_w),
        .cnt_o    (cnt_w),
        .dir_o    (dir_w),
        .reload_o (reload_w)
    );

    pwm_out_stage #(.W(W)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (chan_en),
        .pol_i (polarity),
        .cnt_i (cnt_w),
        .dir_i (dir_w),
        .per_i (act_per_w),
        .dut_i (act_dut_w),
        .pwm_o (pwm_out)
    );
endmodule

// File: rtl/pwm_dual_chan_chk.sv
// Module: pwm_dual_chan_chk
// Property checker for pwm_dual_chan, attached with bind.
module pwm_dual_chan_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick_en,
    input logic         chan_en,
    input logic         center_mode,
    input logic         polarity,
    input logic         pwm_out,
    input logic [W-1:0] cnt,
    input logic         dir_up,
    input logic [W-1:0] act_per
);
    // R8: a disabled channel drives the inverse of polarity one clock later.
    a_r8_disabled_level: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> (pwm_out == !$past(polarity)));

    // R8: a disabled channel holds its count at zero, counting up.
    a_r8_count_parked: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> (cnt == '0 && dir_up));

    // R10: no tick, no movement.
    a_r10_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && $past(chan_en) && !tick_en) |=> ($stable(cnt) && $stable(dir_up)));

    // R2: the left-aligned count stays below the period.
    a_r2_left_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && !center_mode && act_per != '0) |-> (cnt < act_per));

    // R5: the center-aligned count never passes the period.
    a_r5_center_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && center_mode) |-> (cnt <= act_per));

    // R7: the active period changes only when the count is back at zero.
    a_r7_reload_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && cnt != '0) |=> (cnt == '0 || $stable(act_per)));

    // R9: a zero period drives the polarity level.
    a_r9_zero_period: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && act_per == '0) |=> (pwm_out == $past(polarity)));
endmodule

bind pwm_dual_chan pwm_dual_chan_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .chan_en     (chan_en),
    .center_mode (center_mode),
    .polarity    (polarity),
    .pwm_out     (pwm_out),
    .cnt         (cnt_w),
    .dir_up      (dir_w == pwm_pkg::DIR_UP),
    .act_per     (act_per_w)
);

// File: tb/sim_pwm_dual_chan.sv
`timescale 1ns/1ps
module sim_pwm_dual_chan;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_en = 1'b0;
    logic         chan_en = 1'b0;
    logic         center_mode = 1'b0;
    logic         polarity = 1'b0;
    logic         wr_period = 1'b0;
    logic         wr_duty = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         pwm_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    string cur_tag = "R1";

    always #2.5 clk = ~clk;

    pwm_dual_chan #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .chan_en(chan_en),
        .center_mode(center_mode), .polarity(polarity), .wr_period(wr_period),
        .wr_duty(wr_duty), .wr_data(wr_data), .pwm_out(pwm_out)
    );

    // Bench model of the requirements.
    logic [W-1:0] m_cnt, m_sper, m_sdut, m_aper, m_adut;
    logic         m_up, m_out;

    function automatic logic exp_level(logic en, logic pol, logic [W-1:0] c,
                                       logic up, logic [W-1:0] p, logic [W-1:0] d);
        logic win;
        if (!en) return ~pol;
        if (p == 0) return pol;
        win = up ? (c < d) : (c <= d);
        return win ? pol : ~pol;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= 0; m_sper <= 0; m_sdut <= 0; m_aper <= 0; m_adut <= 0;
            m_up <= 1'b1; m_out <= 1'b0;
        end else begin
            logic rl;
            rl = 1'b0;
            m_out <= exp_level(chan_en, polarity, m_cnt, m_up, m_aper, m_adut);
            if (wr_period) m_sper <= wr_data;
            if (wr_duty)   m_sdut <= wr_data;
            if (!chan_en) begin
                m_cnt <= 0; m_up <= 1'b1; rl = 1'b1;
            end else if (tick_en) begin
                if (m_aper == 0) begin
                    m_cnt <= 0; m_up <= 1'b1; rl = 1'b1;
                end else if (!center_mode) begin
                    m_up <= 1'b1;
                    if (int'(m_cnt) + 1 >= int'(m_aper)) begin m_cnt <= 0; rl = 1'b1; end
                    else m_cnt <= m_cnt + 1'b1;
                end else if (m_up) begin
                    m_cnt <= m_cnt + 1'b1;
                    if (int'(m_cnt) + 1 >= int'(m_aper)) m_up <= 1'b0;
                end else if (m_cnt <= 1) begin
                    m_cnt <= 0; m_up <= 1'b1; rl = 1'b1;
                end else m_cnt <= m_cnt - 1'b1;
            end
            if (rl) begin m_aper <= m_sper; m_adut <= m_sdut; end
        end
    end

    task automatic check(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    // Continuous comparison half a cycle after each edge.
    always @(negedge clk) begin
        if (rst_n && !done) check(cur_tag, int'(pwm_out), int'(m_out));
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(bit is_per, logic [W-1:0] v);
        @(negedge clk);
        wr_period = is_per; wr_duty = !is_per; wr_data = v;
        @(negedge clk);
        wr_period = 1'b0; wr_duty = 1'b0;
    endtask

    task automatic setup(bit ctr, bit pol, logic [W-1:0] p, logic [W-1:0] d);
        @(negedge clk);
        chan_en = 1'b0; center_mode = ctr; polarity = pol;
        wr(1'b1, p);
        wr(1'b0, d);
        cyc(2);
        chan_en = 1'b1;
    endtask

    task automatic count_high(int n, output int hi);
        hi = 0;
        repeat (n) begin @(negedge clk); hi += int'(pwm_out); end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int hi;
        void'($urandom(32'h5eed1234));
        // R1: output low while in reset.
        cyc(3);
        check("R1", int'(pwm_out), 0);
        rst_n = 1'b1;
        cyc(2);
        // R8: disabled with polarity 0 drives high.
        cur_tag = "R8";
        check("R8", int'(pwm_out), 1);

        // R3: period 4, duty 1, polarity 0 -> 3 of 4 high.
        cur_tag = "R3"; tick_en = 1'b1;
        setup(1'b0, 1'b0, 8'd4, 8'd1);
        cyc(10); count_high(4, hi); check("R3", hi, 3);
        // R2/R3: polarity 1, period 5, duty 2 -> 2 of 5 high; 10-cycle window.
        cur_tag = "R2";
        setup(1'b0, 1'b1, 8'd5, 8'd2);
        cyc(10); count_high(10, hi); check("R2", hi, 4);
        // R4: duty above period -> fully at polarity level; duty 0 -> never.
        cur_tag = "R4";
        setup(1'b0, 1'b1, 8'd4, 8'd9);
        cyc(10); count_high(8, hi); check("R4", hi, 8);
        setup(1'b1, 1'b1, 8'd4, 8'd0);
        cyc(10); count_high(8, hi); check("R4", hi, 0);
        // R5/R6: center, period 4, duty 1, polarity 1 -> 2 of 8 high.
        cur_tag = "R6";
        setup(1'b1, 1'b1, 8'd4, 8'd1);
        cyc(12); count_high(8, hi); check("R6", hi, 2);
        cur_tag = "R5";
        count_high(16, hi); check("R5", hi, 4);
        setup(1'b1, 1'b0, 8'd3, 8'd2);
        cyc(12); count_high(6, hi); check("R5", hi, 2);
        // R9: zero period -> polarity level whatever the duty.
        cur_tag = "R9";
        setup(1'b0, 1'b1, 8'd0, 8'd3);
        cyc(6); count_high(10, hi); check("R9", hi, 10);
        setup(1'b1, 1'b0, 8'd0, 8'd0);
        cyc(6); count_high(10, hi); check("R9", hi, 0);
        // R10: without ticks the output holds.
        cur_tag = "R10";
        setup(1'b0, 1'b1, 8'd6, 8'd3);
        cyc(8); tick_en = 1'b0; cyc(2);
        hi = int'(pwm_out);
        begin
            int h2;
            count_high(20, h2); check("R10", h2, 20 * hi);
        end
        tick_en = 1'b1;
        // R7: duty write mid-period lands at the wrap only (model-checked).
        cur_tag = "R7";
        setup(1'b0, 1'b1, 8'd8, 8'd2);
        cyc(11); wr(1'b0, 8'd6); cyc(20);
        count_high(8, hi); check("R7", hi, 6);
        // R8: enabling after writes uses the latest values immediately.
        cur_tag = "R8";
        setup(1'b0, 1'b0, 8'd2, 8'd1);
        cyc(1); check("R8", int'(pwm_out), 0);

        // Constrained random segments, compared every cycle (R11).
        cur_tag = "R11";
        for (int s = 0; s < 150; s++) begin
            logic [W-1:0] p, d;
            p = W'($urandom_range(0, 12));
            if ($urandom_range(0, 9) == 0) p = W'($urandom_range(13, 255));
            d = W'($urandom_range(0, int'(p) + 2));
            @(negedge clk); tick_en = 1'b0;
            setup(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), p, d);
            for (int k = 0; k < 300; k++) begin
                @(negedge clk);
                tick_en = ($urandom_range(0, 3) != 0);
                if ($urandom_range(0, 40) == 0) begin
                    wr_period = 1'b1; wr_data = W'($urandom_range(0, 12));
                end else if ($urandom_range(0, 30) == 0) begin
                    wr_duty = 1'b1; wr_data = W'($urandom_range(0, 14));
                end else begin
                    wr_period = 1'b0; wr_duty = 1'b0;
                end
            end
            @(negedge clk); wr_period = 1'b0; wr_duty = 1'b0;
        end
        cyc(2);
        finish_run();
    end
endmodule